// File: doc/BRIEF.md
# Memory-Mapped Configuration RAM Port

This block puts a configuration SRAM onto a plain synchronous port that a microprocessor's general I/O lines can drive. A 24-bit address, a 16-bit write word, a write enable and a width select are all captured together on every rising clock edge. Each edge is one complete access. With the write enable high, the addressed word is updated. With it low, the word is read back and appears on the read bus one clock later. There is no framing, preamble or header, so a single word anywhere in the array can be rewritten on its own. The full array can be read and written.

The width select picks between a 16-bit word access (24 + 16 = 40 bits per transfer) and a byte access (24 + 8 = 32 bits per transfer). A byte access uses only the low lane of the addressed word. The array is organised as byte lanes, and its depth is a parameter. Addresses at or above that depth fall outside the array: writes to them are dropped and reads of them return zero.

The port has no valid/ready handshake and never applies back-pressure. Every clock edge outside reset is an accepted access. A host that has nothing to do should hold the write enable low and present a harmless address.

Top module: `cfg_ram_port`

## Requirements
- R1: With `cfg_we`=1, `cfg_wide`=1 and `cfg_addr` < DEPTH, all 16 bits of `cfg_wdata` are stored at that address on the sampling edge.
- R2: With `cfg_we`=0 and `cfg_wide`=1 at an in-range address, `cfg_rdata` shows the stored 16-bit word from the edge that samples the read, which is one clock after the address is presented.
- R3: With `cfg_we`=1 and `cfg_wide`=0, only bits 7:0 of the addressed word take `cfg_wdata[7:0]`, and bits 15:8 keep their old value.
- R4: A read with `cfg_wide`=0 returns the low byte on `cfg_rdata[7:0]` and zero on `cfg_rdata[15:8]`.
- R5: A write to an address >= DEPTH changes no word in the array, including the word whose index equals the low address bits.
- R6: A read of an address >= DEPTH returns 0 in both width modes.
- R7: A write followed on the very next clock by a read of the same address returns the newly written value.
- R8: `cfg_rdata` holds its value through every cycle that has `cfg_we`=1.
- R9: While `rst_n` is low, and after it is released until the first read, `cfg_rdata` is 0.
- R10: Rewriting one word leaves its neighbouring addresses unchanged. No preamble or other access is needed before or after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; every rising edge performs one access |
| rst_n | input | 1 | Active-low reset of the read register |
| cfg_addr | input | 24 | Word address of the access |
| cfg_wdata | input | 16 | Write word; only bits 7:0 are used in byte mode |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_wide | input | 1 | 1 = 16-bit word access, 0 = 8-bit access on the low lane |
| cfg_rdata | output | 16 | Read word, registered, one clock after the read |

## Verification
Word writes are driven with all-zeros, all-ones, alternating-bit and walking-one patterns at the lowest and highest legal addresses. These patterns show whether any bit is stuck, swapped or dropped. Byte writes and byte reads are then mixed on words that already hold distinct upper bytes, so a leak from the low lane into the upper lane is caught. Writes and reads are aimed just past the array and at the top of the 24-bit space, which separates correct range decoding from aliasing on the low address bits. Back-to-back write-then-read pairs and rewrites between written neighbours expose stale reads and disturbance of adjacent words.

// File: rtl/cfg_ram_pkg.sv
package cfg_ram_pkg;

  // Fixed transfer geometry of the port
  localparam int unsigned CFG_ADDR_W = 24;
  localparam int unsigned CFG_LANE_W = 8;
  localparam int unsigned CFG_LANES  = 2;
  localparam int unsigned CFG_DATA_W = CFG_LANE_W * CFG_LANES;

  // Access width selected per transfer
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_width_e;

  typedef logic [CFG_ADDR_W-1:0] cfg_addr_t;
  typedef logic [CFG_DATA_W-1:0] cfg_word_t;
  typedef logic [CFG_LANE_W-1:0] cfg_lane_t;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_ram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  cfg_addr_t        addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  localparam cfg_addr_t LIMIT = CFG_ADDR_W'(DEPTH);

  always_comb begin
    hit = (addr < LIMIT);
    idx = addr[IDX_W-1:0];
  end

endmodule

// File: rtl/cfg_lane_bank.sv
module cfg_lane_bank
  import cfg_ram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  cfg_lane_t        wr_lane,
  output cfg_lane_t        rd_lane
);

  cfg_lane_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= wr_lane;
    end
  end

  assign rd_lane = mem[idx];

  // R1: an enabled lane write lands in the addressed cell
  assert_lane_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(idx)] == $past(wr_lane));

  // R3: a lane that is not enabled keeps its old content
  assert_lane_keeps_content_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> mem[$past(idx)] == $past(mem[idx]));

endmodule

// File: rtl/cfg_read_shape.sv
module cfg_read_shape
  import cfg_ram_pkg::*;
(
  input  logic                                  hit,
  input  xfer_width_e                           width,
  input  logic [CFG_LANES-1:0][CFG_LANE_W-1:0]  lanes,
  output cfg_word_t                             word
);

  for (genvar g = 0; g < CFG_LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign word[g*CFG_LANE_W +: CFG_LANE_W] = hit ? lanes[g] : '0;
    end else begin : g_high
      assign word[g*CFG_LANE_W +: CFG_LANE_W] =
        (hit && width == XFER_WORD) ? lanes[g] : '0;
    end
  end

endmodule

// File: rtl/cfg_ram_port.sv
module cfg_ram_port
  import cfg_ram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        cfg_we,
  input  logic        cfg_wide,
  output logic [15:0] cfg_rdata
);

  logic                                 hit;
  logic [IDX_W-1:0]                     idx;
  xfer_width_e                          width;
  logic [CFG_LANES-1:0]                 lane_we;
  logic [CFG_LANES-1:0][CFG_LANE_W-1:0] lane_rd;
  cfg_word_t                            shaped;
  cfg_word_t                            rdata_q;

  assign width = xfer_width_e'(cfg_wide);

  cfg_addr_decode #(.DEPTH(DEPTH)) u_decode (
    .addr (cfg_addr),
    .hit  (hit),
    .idx  (idx)
  );

  // One bank per byte lane; upper lanes join only word-wide writes
  for (genvar g = 0; g < CFG_LANES; g++) begin : g_bank
    if (g == 0) begin : g_low
      assign lane_we[g] = cfg_we && hit;
    end else begin : g_high
      assign lane_we[g] = cfg_we && hit && (width == XFER_WORD);
    end

    cfg_lane_bank #(.DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lane_we[g]),
      .idx     (idx),
      .wr_lane (cfg_wdata[g*CFG_LANE_W +: CFG_LANE_W]),
      .rd_lane (lane_rd[g])
    );
  end

  cfg_read_shape u_shape (
    .hit   (hit),
    .width (width),
    .lanes (lane_rd),
    .word  (shaped)
  );

  // Read register: loads on read cycles, holds on write cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (!cfg_we) begin
      rdata_q <= shaped;
    end
  end

  assign cfg_rdata = rdata_q;

  // R8: write cycles leave the read bus untouched
  assert_rdata_holds_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> $stable(cfg_rdata));

  // R6: a read outside the array yields zero
  assert_out_of_range_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !hit) |=> cfg_rdata == '0);

  // R4: a byte read clears the upper lane
  assert_byte_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !cfg_wide) |=> cfg_rdata[15:8] == 8'h00);

  // R5: an out-of-range access never enables a bank
  assert_no_bank_write_out_of_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> lane_we == '0);

endmodule

// File: tb/tb_cfg_ram_port.sv
`timescale 1ns/1ps
module tb_cfg_ram_port;

  localparam int unsigned DEPTH = 256;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cfg_addr = 24'h000100;
  logic [15:0] cfg_wdata = 16'h0000;
  logic        cfg_we = 1'b0;
  logic        cfg_wide = 1'b1;
  logic [15:0] cfg_rdata;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  sb_item_t    sb_q[$];
  logic [15:0] ref_mem [DEPTH];
  logic [15:0] ref_rdata = 16'h0000;

  always #2.5 clk = ~clk;

  cfg_ram_port #(.DEPTH(DEPTH)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_we    (cfg_we),
    .cfg_wide  (cfg_wide),
    .cfg_rdata (cfg_rdata)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, expected read bus pushed to the scoreboard
  task automatic op(input logic we, input logic wide, input logic [23:0] addr,
                    input logic [15:0] wd, input string tag);
    sb_item_t it;
    logic inr;
    @(negedge clk);
    cfg_we = we; cfg_wide = wide; cfg_addr = addr; cfg_wdata = wd;
    inr = (addr < 24'(DEPTH));
    if (we) begin
      if (inr) begin
        ref_mem[addr[7:0]][7:0] = wd[7:0];
        if (wide) ref_mem[addr[7:0]][15:8] = wd[15:8];
      end
    end else begin
      if (!inr) ref_rdata = 16'h0000;
      else if (wide) ref_rdata = ref_mem[addr[7:0]];
      else ref_rdata = {8'h00, ref_mem[addr[7:0]][7:0]};
    end
    it.exp = ref_rdata;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares just after the edge that samples each access
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(cfg_rdata, it.exp, it.tag);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(cfg_rdata, 16'h0000, "R9 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata, 16'h0000, "R9 after reset");

    // R1/R2/R8: word patterns at the array edges
    op(1, 1, 24'h000000, 16'hA55A, "R8 hold on write");
    op(1, 1, 24'h0000FF, 16'hFFFF, "R8 hold on write");
    op(1, 1, 24'h000001, 16'h0000, "R8 hold on write");
    op(1, 1, 24'h000005, 16'h1234, "R8 hold on write");
    op(0, 1, 24'h000000, 16'h0000, "R2 read A55A");
    op(0, 1, 24'h0000FF, 16'h0000, "R1 read FFFF");
    op(0, 1, 24'h000001, 16'h0000, "R1 read 0000");
    for (int i = 0; i < 16; i++) begin
      op(1, 1, 24'(16 + i), 16'(1 << i), "R1 walking write");
    end
    for (int i = 0; i < 16; i++) begin
      op(0, 1, 24'(16 + i), 16'h0000, "R2 walking read");
    end

    // R3/R4: byte lane behaviour
    op(1, 1, 24'h000001, 16'h9E00, "R8 hold on write");
    op(1, 0, 24'h000001, 16'h77C3, "R8 hold on byte write");
    op(0, 1, 24'h000001, 16'h0000, "R3 upper byte kept");
    op(0, 0, 24'h0000FF, 16'h0000, "R4 byte read FF");
    op(0, 0, 24'h000000, 16'h0000, "R4 byte read 5A");

    // R5/R6: outside the array
    op(1, 1, 24'h000105, 16'hDEAD, "R8 hold on oor write");
    op(1, 0, 24'hFFFF05, 16'hBEEF, "R8 hold on oor write");
    op(0, 1, 24'h000005, 16'h0000, "R5 alias word unchanged");
    op(0, 1, 24'h000100, 16'h0000, "R6 oor word read");
    op(0, 0, 24'hFFFFFF, 16'h0000, "R6 oor byte read");

    // R7: write then read next clock
    op(1, 1, 24'h000040, 16'h5AA5, "R8 hold on write");
    op(0, 1, 24'h000040, 16'h0000, "R7 read after write");
    op(1, 0, 24'h000040, 16'h0011, "R8 hold on byte write");
    op(0, 1, 24'h000040, 16'h0000, "R7 read after byte write");

    // R10: rewrite one word between written neighbours
    op(1, 1, 24'h00007E, 16'h1111, "R8 hold on write");
    op(1, 1, 24'h00007F, 16'h2222, "R8 hold on write");
    op(1, 1, 24'h000080, 16'h3333, "R8 hold on write");
    op(1, 1, 24'h00007F, 16'hCAFE, "R8 hold on rewrite");
    op(0, 1, 24'h00007E, 16'h0000, "R10 lower neighbour");
    op(0, 1, 24'h00007F, 16'h0000, "R10 rewritten word");
    op(0, 1, 24'h000080, 16'h0000, "R10 upper neighbour");

    op(0, 1, 24'h000100, 16'h0000, "R6 idle read");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule